// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block sits between a register interface and a successive-approximation converter. It runs the digital side of a batch of conversions. A single control write sets up and starts a sequence. The write chooses how channels are picked (one channel repeated, or an aligned group of channels), whether the sequence holds four or eight conversions, whether it runs once or repeats for ever, and a 4-bit channel code. The controller then walks through the positions. For each one it presents the channel number and the kind of input (external pin, one of the internal reference levels, or the reserved test input) to the analog front end. It pulses a start request and waits for the converter to report done, and it files the returned value in the result register that matches the position.

Completion is tracked by a sequence-complete flag, one conversion-complete flag per result register, and a counter that points at the next register to be written. A mode input selects how the flags are cleared. With fast clearing off, the control write that starts a new sequence clears them. With fast clearing on, reading a result register clears its own flag, and reading register 0 also clears the sequence flag. A test-mode input lets the flags be written directly.

Top module: `adcSeqCtrl`

## Requirements
- R1: A control write (`ctlWrEn` high at a clock edge) starts a sequence: in the next cycle `convStart` is high and `convCount` is 0. A write while a sequence is running abandons it and restarts the same way; a `convDone` arriving in that cycle is not stored.
- R2: `ctlLen8`=0 gives four conversions per sequence and `ctlLen8`=1 gives eight; a single (non-scan) sequence then stops and `busy` falls.
- R3: With `ctlMulti`=1, position n converts channel {code[3:2], n[1:0]} for length four, or {code[3], n[2:0]} for length eight, so the code's low bits are ignored. The value is stored in result register n.
- R4: With `ctlMulti`=0, every position converts the channel given by all four code bits, and position n still stores into register n. Registers beyond the sequence length keep their values.
- R5: `inKind` decodes the low three bits of `chanSel`: 100 gives 1 (high reference), 101 gives 2 (low reference), 110 gives 3 (midpoint of the references), 111 gives 4 (test input), and any value with bit 2 clear gives 0 (external pin).
- R6: `seqDone` is set when a single sequence ends. With `ctlScan`=1 it is set when the first pass ends, and the sequence keeps repeating from position 0.
- R7: With `fastClr`=0, a control write clears `seqDone` and all of `ccfFlags` at the same edge.
- R8: With `fastClr`=1, a read (`rdEn` with `rdIdx`=n) clears `ccfFlags[n]`, and a read of register 0 also clears `seqDone`. A control write leaves the flags unchanged. `rdData` always shows register `rdIdx`.
- R9: Storing a result into register n sets `ccfFlags[n]` and advances `convCount` to the next position. The count wraps to 0 after position 3 (length four) or position 7 (length eight).
- R10: With `testMode`=1, a status write (`statWrEn`) loads `seqDone` from `statWrScf` and `ccfFlags` from `statWrCcf`, taking priority over every other flag update. With `testMode`=0 the status write has no effect.
- R11: `convStart` is a one-cycle pulse. After a result is stored, the next position's start follows in the very next cycle.
- R12: After reset, `seqDone`, `ccfFlags`, `convCount`, `convStart` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control write: start or restart a sequence |
| ctlMulti | input | 1 | 1 = aligned channel group, 0 = one channel repeated |
| ctlLen8 | input | 1 | 1 = eight conversions, 0 = four |
| ctlScan | input | 1 | 1 = repeat sequences continuously |
| ctlCode | input | 4 | Channel code |
| fastClr | input | 1 | Fast flag clearing mode |
| convStart | output | 1 | Start request to the converter |
| chanSel | output | 4 | Channel presented to the analog front end |
| inKind | output | 3 | Input kind: 0 pin, 1 high ref, 2 low ref, 3 mid ref, 4 test |
| convDone | input | 1 | Converter reports a finished conversion |
| convResult | input | 10 | Converted value, valid with `convDone` |
| rdEn | input | 1 | Result register read strobe |
| rdIdx | input | 3 | Result register index to read |
| rdData | output | 10 | Contents of result register `rdIdx` |
| testMode | input | 1 | Enables direct writes to the flags |
| statWrEn | input | 1 | Status flag write strobe |
| statWrScf | input | 1 | Value written to the sequence flag |
| statWrCcf | input | 8 | Values written to the conversion flags |
| seqDone | output | 1 | Sequence-complete flag |
| ccfFlags | output | 8 | Per-register conversion-complete flags |
| convCount | output | 3 | Index of the next result register to be written |
| busy | output | 1 | A sequence is in progress |

## Verification
On every cycle, the embedded properties check these rules: the start request lasts one cycle, a control write forces position 0 and a start, the count stays below four in four-long sequences, a fast-clear read of register 0 drops the sequence flag, and the flags hold still in normal mode when nothing updates them. The directed scenarios cover what needs a whole sequence to see. They check the channel order for grouped and repeated selection, the placement of results by position, the reference-input decoding, repetition in scan mode, the clearing behaviour under each mode, the abort-and-restart path, and the gating of direct flag writes by test mode.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;
  localparam int IDX_W   = 3;
  localparam int NUM_RES = 1 << IDX_W;
  localparam int CODE_W  = 4;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_WAIT  = 2'd2
  } seqState_t;

  typedef enum logic [2:0] {
    IN_PIN     = 3'd0,
    IN_REF_HI  = 3'd1,
    IN_REF_LO  = 3'd2,
    IN_REF_MID = 3'd3,
    IN_TEST    = 3'd4
  } inKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             store;
    logic [IDX_W-1:0] idx;
    logic             seqEnd;
    logic             restart;
  } seqStrobe_t;
endpackage

// File: rtl/adcSeqCtrlFsm.sv
module adcSeqCtrlFsm
  import adcSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWrEn,
  input  logic              ctlMulti,
  input  logic              ctlLen8,
  input  logic              ctlScan,
  input  logic [CODE_W-1:0] ctlCode,
  input  logic              convDone,
  output logic              convStart,
  output logic [CODE_W-1:0] chanSel,
  output logic [2:0]        inKind,
  output logic [IDX_W-1:0]  convCount,
  output logic              busy,
  output seqStrobe_t        strb
);
  seqState_t         state;
  logic [IDX_W-1:0]  pos;
  logic              multiQ, len8Q, scanQ, firstPass;
  logic [CODE_W-1:0] codeQ;
  logic [IDX_W-1:0]  lastPos;
  logic              atLast;
  logic              takeDone;

  assign lastPos  = len8Q ? IDX_W'(NUM_RES - 1) : IDX_W'(NUM_RES/2 - 1);
  assign atLast   = (pos == lastPos);
  assign takeDone = (state == SQ_WAIT) && convDone && !ctlWrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SQ_IDLE;
      pos       <= '0;
      multiQ    <= 1'b0;
      len8Q     <= 1'b0;
      scanQ     <= 1'b0;
      codeQ     <= '0;
      firstPass <= 1'b0;
    end else if (ctlWrEn) begin
      multiQ    <= ctlMulti;
      len8Q     <= ctlLen8;
      scanQ     <= ctlScan;
      codeQ     <= ctlCode;
      pos       <= '0;
      firstPass <= 1'b1;
      state     <= SQ_START;
    end else begin
      case (state)
        SQ_START: state <= SQ_WAIT;
        SQ_WAIT: begin
          if (takeDone) begin
            if (atLast) begin
              pos       <= '0;
              firstPass <= 1'b0;
              state     <= scanQ ? SQ_START : SQ_IDLE;
            end else begin
              pos   <= pos + 1'b1;
              state <= SQ_START;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // channel generation
  always_comb begin
    if (!multiQ)
      chanSel = codeQ;
    else if (len8Q)
      chanSel = {codeQ[CODE_W-1:IDX_W], pos};
    else
      chanSel = {codeQ[CODE_W-1:IDX_W-1], pos[IDX_W-2:0]};
  end

  always_comb begin
    inKind_t k;
    if (!chanSel[2])
      k = IN_PIN;
    else begin
      case (chanSel[1:0])
        2'b00:   k = IN_REF_HI;
        2'b01:   k = IN_REF_LO;
        2'b10:   k = IN_REF_MID;
        default: k = IN_TEST;
      endcase
    end
    inKind = k;
  end

  assign convStart    = (state == SQ_START);
  assign busy         = (state != SQ_IDLE);
  assign convCount    = pos;
  assign strb.store   = takeDone;
  assign strb.idx     = pos;
  assign strb.seqEnd  = takeDone && atLast && firstPass;
  assign strb.restart = ctlWrEn;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R11
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> (convStart && convCount == '0)); // R1
  AST_COUNT_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !len8Q) |-> (convCount < IDX_W'(NUM_RES/2))); // R9
endmodule

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcSeqPkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic [RES_W-1:0]   convResult,
  input  logic               fastClr,
  input  logic               rdEn,
  input  logic [IDX_W-1:0]   rdIdx,
  input  logic               testMode,
  input  logic               statWrEn,
  input  logic               statWrScf,
  input  logic [NUM_RES-1:0] statWrCcf,
  output logic [RES_W-1:0]   rdData,
  output logic               seqDone,
  output logic [NUM_RES-1:0] ccfFlags
);
  logic [RES_W-1:0]   resReg [NUM_RES];
  logic [NUM_RES-1:0] ccfQ, ccfNext;
  logic               scfQ, scfNext;
  logic               testWr;

  assign testWr = testMode && statWrEn;

  for (genvar g = 0; g < NUM_RES; g++) begin : gRes
    always_ff @(posedge clk) begin
      if (!rstN)
        resReg[g] <= '0;
      else if (strb.store && strb.idx == IDX_W'(g))
        resReg[g] <= convResult;
    end
  end

  always_comb begin
    ccfNext = ccfQ;
    scfNext = scfQ;
    if (strb.restart && !fastClr) begin
      ccfNext = '0;
      scfNext = 1'b0;
    end
    if (rdEn && fastClr) begin
      ccfNext[rdIdx] = 1'b0;
      if (rdIdx == '0) scfNext = 1'b0;
    end
    if (strb.store)  ccfNext[strb.idx] = 1'b1;
    if (strb.seqEnd) scfNext = 1'b1;
    if (testWr) begin
      ccfNext = statWrCcf;
      scfNext = statWrScf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccfQ <= '0;
      scfQ <= 1'b0;
    end else begin
      ccfQ <= ccfNext;
      scfQ <= scfNext;
    end
  end

  assign rdData   = resReg[rdIdx];
  assign seqDone  = scfQ;
  assign ccfFlags = ccfQ;

  AST_FAST_READ0: assert property (@(posedge clk) disable iff (!rstN)
    (fastClr && rdEn && rdIdx == '0 && !strb.seqEnd && !testWr) |=> !seqDone); // R8
  AST_SLOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.restart && !fastClr && !testWr) |=> (!seqDone && ccfFlags == '0)); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!testMode && !strb.store && !strb.restart && !rdEn) |=> ($stable(ccfFlags) && $stable(seqDone))); // R10
endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctlWrEn,
  input  logic               ctlMulti,
  input  logic               ctlLen8,
  input  logic               ctlScan,
  input  logic [CODE_W-1:0]  ctlCode,
  input  logic               fastClr,
  output logic               convStart,
  output logic [CODE_W-1:0]  chanSel,
  output logic [2:0]         inKind,
  input  logic               convDone,
  input  logic [RES_W-1:0]   convResult,
  input  logic               rdEn,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [RES_W-1:0]   rdData,
  input  logic               testMode,
  input  logic               statWrEn,
  input  logic               statWrScf,
  input  logic [NUM_RES-1:0] statWrCcf,
  output logic               seqDone,
  output logic [NUM_RES-1:0] ccfFlags,
  output logic [IDX_W-1:0]   convCount,
  output logic               busy
);
  seqStrobe_t strb;

  adcSeqCtrlFsm i_fsm (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlMulti(ctlMulti),
    .ctlLen8(ctlLen8), .ctlScan(ctlScan), .ctlCode(ctlCode),
    .convDone(convDone), .convStart(convStart), .chanSel(chanSel),
    .inKind(inKind), .convCount(convCount), .busy(busy), .strb(strb)
  );

  adcSeqData #(.RES_W(RES_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .convResult(convResult),
    .fastClr(fastClr), .rdEn(rdEn), .rdIdx(rdIdx), .testMode(testMode),
    .statWrEn(statWrEn), .statWrScf(statWrScf), .statWrCcf(statWrCcf),
    .rdData(rdData), .seqDone(seqDone), .ccfFlags(ccfFlags)
  );
endmodule

// File: tb/test_adcSeqCtrl.sv
module test_adcSeqCtrl;
  localparam int RES_W = 10;
  localparam int LAT   = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctlWrEn = 0, ctlMulti = 0, ctlLen8 = 0, ctlScan = 0;
  logic [3:0] ctlCode = '0;
  logic fastClr = 0, convStart, convDone;
  logic [3:0] chanSel;
  logic [2:0] inKind;
  logic [RES_W-1:0] convResult, rdData;
  logic rdEn = 0;
  logic [2:0] rdIdx = '0;
  logic testMode = 0, statWrEn = 0, statWrScf = 0;
  logic [7:0] statWrCcf = '0, ccfFlags;
  logic seqDone, busy;
  logic [2:0] convCount;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adcSeqCtrl #(.RES_W(RES_W)) i_adcSeqCtrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlMulti(ctlMulti),
    .ctlLen8(ctlLen8), .ctlScan(ctlScan), .ctlCode(ctlCode), .fastClr(fastClr),
    .convStart(convStart), .chanSel(chanSel), .inKind(inKind),
    .convDone(convDone), .convResult(convResult), .rdEn(rdEn), .rdIdx(rdIdx),
    .rdData(rdData), .testMode(testMode), .statWrEn(statWrEn),
    .statWrScf(statWrScf), .statWrCcf(statWrCcf), .seqDone(seqDone),
    .ccfFlags(ccfFlags), .convCount(convCount), .busy(busy)
  );

  function automatic logic [RES_W-1:0] sampleOf(input logic [3:0] ch);
    if (ch[2]) begin
      case (ch[1:0])
        2'b00:   return 10'h3FF;
        2'b01:   return 10'h000;
        2'b10:   return 10'h200;
        default: return 10'h155;
      endcase
    end
    return 10'h040 + 10'(ch) * 10'd7;
  endfunction

  function automatic logic [2:0] kindOf(input logic [3:0] ch);
    if (!ch[2]) return 3'd0;
    return 3'd1 + 3'(ch[1:0]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // converter model and channel log
  int cnt = 0, logCnt = 0;
  logic logClr = 0;
  logic [3:0] convCh = '0;
  logic [3:0] chLog [64];

  always @(posedge clk) begin
    if (!rstN || logClr) logCnt <= 0;
    if (!rstN) cnt <= 0;
    else if (convStart) begin
      cnt    <= LAT;
      convCh <= chanSel;
      if (!logClr && logCnt < 64) begin
        chLog[logCnt] <= chanSel;
        logCnt <= logCnt + 1;
      end
      chk("R5 inKind", 32'(inKind), 32'(kindOf(chanSel)));
    end else if (cnt > 0) cnt <= cnt - 1;
  end
  assign convDone   = (cnt == 1);
  assign convResult = sampleOf(convCh);

  task automatic startSeq(input logic m, input logic l8, input logic sc, input logic [3:0] code);
    @(negedge clk);
    ctlMulti = m; ctlLen8 = l8; ctlScan = sc; ctlCode = code;
    ctlWrEn = 1; logClr = 1;
    @(negedge clk);
    ctlWrEn = 0; logClr = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic peek(input int idx, output logic [RES_W-1:0] v);
    rdIdx = 3'(idx); #1 v = rdData;
  endtask

  task automatic readClr(input int idx, output logic [RES_W-1:0] v);
    @(negedge clk);
    rdIdx = 3'(idx); rdEn = 1; #1 v = rdData;
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic tReset();
    chk("R12 seqDone", 32'(seqDone), 0);
    chk("R12 ccfFlags", 32'(ccfFlags), 0);
    chk("R12 convCount", 32'(convCount), 0);
    chk("R12 convStart", 32'(convStart), 0);
    chk("R12 busy", 32'(busy), 0);
  endtask

  task automatic tMulti4();
    logic [RES_W-1:0] v;
    startSeq(1, 0, 0, 4'b0110);
    chk("R1 start", 32'(convStart), 1);
    chk("R1 count", 32'(convCount), 0);
    chk("R3 first chan", 32'(chanSel), 4);
    chk("R5 high ref", 32'(inKind), 1);
    @(negedge clk);
    chk("R11 pulse", 32'(convStart), 0);
    waitIdle();
    chk("R2 four convs", 32'(logCnt), 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3 chan order", 32'(chLog[i]), 32'(4 + i));
      peek(i, v);
      chk("R3 result place", 32'(v), 32'(sampleOf(4'(4 + i))));
    end
    chk("R6 seqDone", 32'(seqDone), 1);
    chk("R9 flags", 32'(ccfFlags), 32'h0F);
    chk("R9 wrap", 32'(convCount), 0);
  endtask

  task automatic tMulti8();
    logic [RES_W-1:0] v;
    startSeq(1, 1, 0, 4'b1011);
    waitIdle();
    chk("R2 eight convs", 32'(logCnt), 8);
    for (int i = 0; i < 8; i++) begin
      chk("R3 chan order 8", 32'(chLog[i]), 32'(8 + i));
      peek(i, v);
      chk("R3 result 8", 32'(v), 32'(sampleOf(4'(8 + i))));
    end
    chk("R9 flags 8", 32'(ccfFlags), 32'hFF);
  endtask

  task automatic tSingle();
    logic [RES_W-1:0] v;
    startSeq(0, 0, 0, 4'd9);
    waitIdle();
    chk("R4 count", 32'(logCnt), 4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 same chan", 32'(chLog[i]), 9);
      peek(i, v);
      chk("R4 result", 32'(v), 32'(sampleOf(4'd9)));
    end
    peek(5, v);
    chk("R4 reg5 kept", 32'(v), 32'(sampleOf(4'd13)));
  endtask

  task automatic tSlowClear();
    chk("R7 pre seqDone", 32'(seqDone), 1);
    startSeq(1, 0, 0, 4'b0000);
    chk("R7 seqDone cleared", 32'(seqDone), 0);
    chk("R7 flags cleared", 32'(ccfFlags), 0);
    waitIdle();
  endtask

  task automatic tCount();
    startSeq(1, 1, 0, 4'b0000);
    while (ccfFlags != 8'h07) @(negedge clk);
    chk("R9 next index", 32'(convCount), 3);
    waitIdle();
    chk("R9 wrap 8", 32'(convCount), 0);
  endtask

  task automatic tFastClear();
    logic [RES_W-1:0] v;
    fastClr = 1;
    startSeq(1, 0, 0, 4'b0000);
    chk("R8 write keeps seqDone", 32'(seqDone), 1);
    chk("R8 write keeps flags", 32'(ccfFlags), 32'hFF);
    waitIdle();
    readClr(1, v);
    chk("R8 read data", 32'(v), 32'(sampleOf(4'd1)));
    chk("R8 ccf1 cleared", 32'(ccfFlags), 32'hFD);
    chk("R8 seqDone kept", 32'(seqDone), 1);
    readClr(0, v);
    chk("R8 read0 seqDone", 32'(seqDone), 0);
    chk("R8 read0 flags", 32'(ccfFlags), 32'hFC);
    fastClr = 0;
  endtask

  task automatic tScan();
    startSeq(1, 0, 1, 4'b0000);
    while (logCnt < 6) @(negedge clk);
    chk("R6 scan seqDone", 32'(seqDone), 1);
    chk("R6 scan busy", 32'(busy), 1);
    chk("R6 scan repeat0", 32'(chLog[4]), 0);
    chk("R6 scan repeat1", 32'(chLog[5]), 1);
    startSeq(0, 0, 0, 4'd3);
    waitIdle();
    chk("R2 scan stopped", 32'(busy), 0);
  endtask

  task automatic tAbort();
    logic [RES_W-1:0] v;
    startSeq(1, 1, 0, 4'b1000);
    while (ccfFlags != 8'h03) @(negedge clk);
    startSeq(1, 0, 0, 4'b0100);
    chk("R1 abort count", 32'(convCount), 0);
    chk("R1 abort start", 32'(convStart), 1);
    chk("R1 abort chan", 32'(chanSel), 4);
    waitIdle();
    chk("R1 abort convs", 32'(logCnt), 4);
    for (int i = 0; i < 4; i++) begin
      peek(i, v);
      chk("R1 abort result", 32'(v), 32'(sampleOf(4'(4 + i))));
    end
    chk("R1 abort flags", 32'(ccfFlags), 32'h0F);
  endtask

  task automatic tTestWrite();
    @(negedge clk);
    testMode = 0; statWrEn = 1; statWrScf = 0; statWrCcf = 8'hA5;
    @(negedge clk);
    statWrEn = 0;
    chk("R10 ignored scf", 32'(seqDone), 1);
    chk("R10 ignored ccf", 32'(ccfFlags), 32'h0F);
    testMode = 1; statWrEn = 1;
    @(negedge clk);
    statWrEn = 0;
    chk("R10 written scf", 32'(seqDone), 0);
    chk("R10 written ccf", 32'(ccfFlags), 32'hA5);
    statWrEn = 1; statWrScf = 1;
    @(negedge clk);
    statWrEn = 0; testMode = 0;
    chk("R10 set scf", 32'(seqDone), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tMulti4();
    tMulti8();
    tSingle();
    tSlowClear();
    tCount();
    tFastClear();
    tScan();
    tAbort();
    tTestWrite();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule